// File: doc/BRIEF.md
# Four-State Irregular Sequence Counter

This block is a free-running synchronous counter with no data inputs. On every rising clock edge it moves its 3-bit state one step around a fixed loop that is not in binary order: 000, then 011, then 101, then 010, and back to 000. The state bits are the block's only output. It is used wherever a short repeating code pattern is needed straight from flip-flops.

A compile-time parameter picks the kind of storage behind the state register. With D-type storage the next-state logic drives each bit's new value. With T-type storage the same logic instead drives a toggle enable for each bit, which is high only for bits that must change. Both builds produce the same state trace. An active-high synchronous reset forces the state to 000. The four codes outside the loop all lead to 000 on the next edge, so the counter always returns to the loop.

Top module: `seq_cycle_counter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `stateQ` is 000 after that edge and stays 000 for as long as `rst` stays 1.
- R2: With `rst` at 0, a rising edge in state 000 moves `stateQ` to 011.
- R3: With `rst` at 0, a rising edge in state 011 moves `stateQ` to 101.
- R4: With `rst` at 0, a rising edge in state 101 moves `stateQ` to 010.
- R5: With `rst` at 0, a rising edge in state 010 moves `stateQ` to 000, closing a four-state loop.
- R6: The unused codes 001, 100, 110 and 111 each lead to 000 on the next edge. In the next-state logic (`seq_ctrl`) this shows as a D-build command of 000 for those codes.
- R7: With `USE_TOGGLE` = 0 the per-bit command from `seq_ctrl` is the next state itself. With `USE_TOGGLE` = 1 the per-bit command is a toggle enable equal to the current state XOR the next state. In both builds `clear` in the strobe struct follows `rst`.
- R8: Both builds give identical `stateQ` traces from reset, cycle by cycle. Bit 2 of `stateQ` is the leftmost digit of the codes above, and bit 0 is the rightmost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to state 000 |
| stateQ | output | 3 | Current state, bit 2 leftmost |

## Verification
Every result of this block is due one clock edge after its cause. A step along the loop shows in `stateQ` right after the edge that took it. A reset raised before an edge shows as 000 right after that edge. The bench drives `rst` on falling edges and compares both builds against a reference on the falling edge after each rising edge, when every such result has settled. The next-state logic is combinational, so the sweep over all eight codes is checked after a short settling delay with no clock involved.

// File: rtl/seq_cycle_pkg.sv
package seq_cycle_pkg;
  localparam int STATE_W = 3;

  typedef logic [STATE_W-1:0] state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   clear;   // synchronous reset request
    state_t bitCmd;  // next value (D build) or toggle enables (T build)
  } seqStrobe_t;

  localparam state_t ST_ZERO  = 3'b000;
  localparam state_t ST_ONE   = 3'b011;
  localparam state_t ST_TWO   = 3'b101;
  localparam state_t ST_THREE = 3'b010;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_cycle_pkg::*;
#(
  parameter bit USE_TOGGLE = 1'b0
) (
  input  logic       rst,
  input  state_t     curState,
  output seqStrobe_t strobes
);
  state_t nextState;

  // loop 000 -> 011 -> 101 -> 010 -> 000, all other codes fall back to 000
  always_comb begin
    case (curState)
      ST_ZERO:  nextState = ST_ONE;
      ST_ONE:   nextState = ST_TWO;
      ST_TWO:   nextState = ST_THREE;
      ST_THREE: nextState = ST_ZERO;
      default:  nextState = ST_ZERO;
    endcase
  end

  generate
    if (USE_TOGGLE) begin : g_toggleCmd
      always_comb begin
        strobes.clear  = rst;
        strobes.bitCmd = curState ^ nextState;
      end
    end else begin : g_dataCmd
      always_comb begin
        strobes.clear  = rst;
        strobes.bitCmd = nextState;
      end
    end
  endgenerate
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_cycle_pkg::*;
#(
  parameter bit USE_TOGGLE = 1'b0
) (
  input  logic       clk,
  input  seqStrobe_t strobes,
  output state_t     stateQ
);
  state_t stateReg;

  generate
    for (genvar b = 0; b < STATE_W; b++) begin : g_bit
      if (USE_TOGGLE) begin : g_tff
        always_ff @(posedge clk) begin
          if (strobes.clear) stateReg[b] <= 1'b0;
          else if (strobes.bitCmd[b]) stateReg[b] <= ~stateReg[b];
        end
      end else begin : g_dff
        always_ff @(posedge clk) begin
          if (strobes.clear) stateReg[b] <= 1'b0;
          else stateReg[b] <= strobes.bitCmd[b];
        end
      end
    end
  endgenerate

  assign stateQ = stateReg;
endmodule

// File: rtl/seq_cycle_counter.sv
module seq_cycle_counter #(
  parameter bit USE_TOGGLE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] stateQ
);
  seq_cycle_pkg::seqStrobe_t strobes;
  seq_cycle_pkg::state_t     curState;

  seq_ctrl #(.USE_TOGGLE(USE_TOGGLE)) u_ctrl (
    .rst      (rst),
    .curState (curState),
    .strobes  (strobes)
  );

  seq_datapath #(.USE_TOGGLE(USE_TOGGLE)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .stateQ  (curState)
  );

  assign stateQ = curState;
endmodule

// File: rtl/seq_cycle_counter_chk.sv
module seq_cycle_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] stateQ
);
  logic rstSeen = 1'b0;

  // R1: the edge after a sampled reset leaves 000
  always @(posedge clk) begin
    if (rstSeen) a_r1_reset_zero: assert (stateQ == 3'b000);
    rstSeen <= rst;
  end

  a_r2_step_from_000: assert property (@(posedge clk) disable iff (rst)
    (stateQ == 3'b000) |=> (rst || stateQ == 3'b011));
  a_r3_step_from_011: assert property (@(posedge clk) disable iff (rst)
    (stateQ == 3'b011) |=> (rst || stateQ == 3'b101));
  a_r4_step_from_101: assert property (@(posedge clk) disable iff (rst)
    (stateQ == 3'b101) |=> (rst || stateQ == 3'b010));
  a_r5_step_from_010: assert property (@(posedge clk) disable iff (rst)
    (stateQ == 3'b010) |=> (rst || stateQ == 3'b000));
  // R6: starting from reset, no unused code ever appears
  a_r6_only_loop_codes: assert property (@(posedge clk) disable iff (rst)
    (stateQ == 3'b000 || stateQ == 3'b011 || stateQ == 3'b101 || stateQ == 3'b010));
endmodule

bind seq_cycle_counter seq_cycle_counter_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .stateQ (stateQ)
);

// File: tb/seq_cycle_counter_bench.sv
module seq_cycle_counter_bench;
  import seq_cycle_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] stateD, stateT;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  seq_cycle_counter #(.USE_TOGGLE(1'b0)) u_seq_cycle_counter (
    .clk(clk), .rst(rst), .stateQ(stateD));
  seq_cycle_counter #(.USE_TOGGLE(1'b1)) u_seq_cycle_counter_t (
    .clk(clk), .rst(rst), .stateQ(stateT));

  // standalone next-state logic for the full code sweep
  logic probeRst = 1'b0;
  state_t probeState = '0;
  seqStrobe_t probeD, probeT;
  seq_ctrl #(.USE_TOGGLE(1'b0)) u_probeD (.rst(probeRst), .curState(probeState), .strobes(probeD));
  seq_ctrl #(.USE_TOGGLE(1'b1)) u_probeT (.rst(probeRst), .curState(probeState), .strobes(probeT));

  // behavioural reference: a position in a list of loop codes
  int loopCodes[$] = '{3'b000, 3'b011, 3'b101, 3'b010};
  int refPos = 0;

  function automatic int expectedNext(int code);
    for (int i = 0; i < loopCodes.size(); i++)
      if (loopCodes[i] == code) return loopCodes[(i + 1) % loopCodes.size()];
    return 0;
  endfunction

  task automatic check(string req, int actual, int expected);
    vectors++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %03b expected %03b at %0t", req, actual, expected, $time);
    end
  endtask

  always @(posedge clk) refPos <= rst ? 0 : (refPos + 1) % 4;

  task automatic stepAndCheck(string req);
    @(negedge clk);
    check({req, " D build"}, stateD, loopCodes[refPos]);
    check({req, " T build"}, stateT, loopCodes[refPos]);
    check("R8 builds agree", stateT, stateD);
  endtask

  task automatic tagFor(int code, output string req);
    case (code)
      3'b000: req = "R2";
      3'b011: req = "R3";
      3'b101: req = "R4";
      default: req = "R5";
    endcase
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    string req;
    // R1: reset held for several edges
    repeat (3) stepAndCheck("R1 reset");
    check("R1 reset value", stateD, 3'b000);
    @(negedge clk) rst = 1'b0;
    // free run: R2..R5 and R8 along several laps
    for (int n = 0; n < 13; n++) begin
      tagFor(loopCodes[refPos], req);
      stepAndCheck(req);
    end
    // R1: mid-run resets at each loop phase
    for (int ph = 0; ph < 4; ph++) begin
      repeat (ph + 1) stepAndCheck("R8 run");
      rst = 1'b1;
      stepAndCheck("R1 midrun");
      check("R1 midrun zero", stateT, 3'b000);
      stepAndCheck("R1 hold");
      rst = 1'b0;
      stepAndCheck("R2 after reset");
      check("R2 after reset", stateD, 3'b011);
    end
    // R6/R7: sweep every code through the next-state logic
    for (int c = 0; c < 8; c++) begin
      probeState = state_t'(c);
      probeRst = 1'b0;
      #1;
      check(expectedNext(c) == 0 && c != 3'b010 ? "R6 unused code" : "R7 D command",
            probeD.bitCmd, expectedNext(c));
      check("R7 T toggle enables", probeT.bitCmd, c ^ expectedNext(c));
      check("R7 clear low", {2'b0, probeD.clear | probeT.clear}, 0);
      probeRst = 1'b1;
      #1;
      check("R7 clear follows rst", {2'b0, probeD.clear & probeT.clear}, 1);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule